// File: doc/BRIEF.md
# Latched Status and Warning Register

This block gathers fault and warning events from a quadrature counter and its surrounding logic into three status bytes that two independent serial read ports can fetch. An event pulse latches its bit, and the bit stays set until a read of the byte that holds it clears it. A few bits have their own rules. The touch-probe pin bit is a live, synchronized copy of the pin. The reference-valid bit is not cleared by status reads. The two capture-valid bits also clear when their own data registers are read.

The block watches the raw A and B quadrature inputs itself. It raises a decode error when the two lines change in the same cycle, or when one transition follows the previous one within a programmable number of clocks. Two summary outputs are provided. One flags the two error bits. The other flags every other latched bit, all of which are warnings.

Top module: `quad_status_reg`

## Requirements
- R1: The status bytes sit at BASE_ADDR (byte 0), BASE_ADDR+1 (byte 1) and BASE_ADDR+2 (byte 2), with BASE_ADDR defaulting to 0x48. Byte 0 holds: bit 0 decode error, bit 1 external error, bits 7:2 ev_warn[5:0]. Byte 1 holds: bit 0 probe-valid, bit 1 update-valid, bit 2 reference-valid, bit 3 live probe pin, bits 7:4 ev_warn[9:6]. Byte 2 holds ev_warn[17:10]. A read of any other address returns 0x00 and clears nothing.
- R2: A one-cycle event pulse sets its bit at the next clock edge. The bit then stays set until a clearing read.
- R3: A status read returns, on its port's data output one clock later, the byte as it stood before that edge. It clears only the latched bits of that byte.
- R4: Each read port clears the bits it reads on its own. Both ports may read the same byte in the same cycle, and both then see the same pre-clear value.
- R5: The reference-valid bit (byte 1 bit 2) is not cleared by status reads. Only reset clears it.
- R6: A pulse on rd_probe clears probe-valid (byte 1 bit 0). A pulse on rd_update clears update-valid (byte 1 bit 1). Neither pulse touches any other bit.
- R7: Byte 1 bit 3 reads the probe pin after a two-stage synchronizer. It is never latched, a read never clears it, and it does not feed warn_o.
- R8: An event arriving in the same cycle as a read that would clear its bit leaves the bit set.
- R9: err_o is high while either error bit (byte 0 bits 1:0) is set. warn_o is high while any other latched bit is set.
- R10: With min_gap = N > 0, an A or B transition that comes k ≤ N clocks after the previous transition sets the decode error. A spacing of k = N+1 does not set it.
- R11: A and B changing in the same cycle set the decode error, even with min_gap = 0.
- R12: After reset all latched bits, err_o, warn_o and both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_a | input | 1 | Raw quadrature line A |
| ab_b | input | 1 | Raw quadrature line B |
| min_gap | input | GAP_W | Minimum transition spacing in clocks; 0 disables the spacing check |
| ev_ext | input | 1 | External error event pulse |
| ev_warn | input | 18 | Warning event pulses, mapped as in R1 |
| ev_tpval | input | 1 | Probe capture done pulse |
| ev_updval | input | 1 | Update capture done pulse |
| ev_rval | input | 1 | Reference valid event pulse |
| tpi | input | 1 | Touch probe pin (asynchronous) |
| rd_probe | input | 1 | Probe data register read strobe |
| rd_update | input | 1 | Update data register read strobe |
| pa_rd | input | 1 | Port A read strobe |
| pa_addr | input | ADDR_W | Port A read address |
| pa_data | output | 8 | Port A read data, valid one clock after the strobe |
| pb_rd | input | 1 | Port B read strobe |
| pb_addr | input | ADDR_W | Port B read address |
| pb_data | output | 8 | Port B read data, valid one clock after the strobe |
| err_o | output | 1 | Error summary |
| warn_o | output | 1 | Warning summary |

## Verification
An event pulse shows in the latched bits and on err_o or warn_o at the first clock edge after it is driven. Read data shows at the first edge after the strobe and carries the value from before that edge. The probe pin is seen by a read two edges after it changes, and a quadrature transition reaches the decode-error bit three edges after it is driven. The bench drives inputs on the falling edge and keeps a model that it advances once per rising edge. It compares every output on the next falling edge and keeps a two-deep history of the pin for the synchronizer delay. For the quadrature cases the bench waits out the pipeline, then reads the byte back and compares only the decode bit.

// File: rtl/qsr_pkg.sv
// Shared constants for the latched status register: byte count, bit
// positions and per-byte masks. Assumes three 8-bit status bytes.
package qsr_pkg;
    localparam int NUM_BYTES  = 3;
    localparam int BYTE_W     = 8;
    localparam int WARN_W     = 18;
    localparam int FLAT_W     = NUM_BYTES * BYTE_W;

    localparam int DEC_POS    = 0;   // byte 0
    localparam int EXT_POS    = 1;   // byte 0
    localparam int PVAL_POS   = 0;   // byte 1
    localparam int UVAL_POS   = 1;   // byte 1
    localparam int RVAL_POS   = 2;   // byte 1
    localparam int PIN_POS    = 3;   // byte 1

    typedef logic [BYTE_W-1:0] stbyte_t;

    // Bits that hold a latch (the live pin bit has none).
    function automatic stbyte_t used_mask(input int idx);
        return (idx == 1) ? stbyte_t'(8'hF7) : stbyte_t'(8'hFF);
    endfunction

    // Bits that a status read leaves alone.
    function automatic stbyte_t keep_mask(input int idx);
        return (idx == 1) ? stbyte_t'(8'h04) : stbyte_t'(8'h00);
    endfunction

    // Bits that count as errors rather than warnings.
    function automatic stbyte_t err_mask(input int idx);
        return (idx == 0) ? stbyte_t'(8'h03) : stbyte_t'(8'h00);
    endfunction
endpackage

// File: rtl/qsr_sync2.sv
// Two-stage synchronizer for W asynchronous inputs.
// Assumes the inputs are level signals that hold for several clocks.
module qsr_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Move the inputs through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/qsr_edge_guard.sv
// Quadrature decode checker. It synchronizes A and B, finds their
// transitions, and flags a transition that follows the previous one within
// min_gap clocks, or A and B changing together. dec_err is a one-cycle
// combinational pulse. Assumes the reset levels of A and B are low.
module qsr_edge_guard #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_in,
    input  logic             b_in,
    input  logic [GAP_W-1:0] min_gap,
    output logic             dec_err
);
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic [1:0]       ab_sync;
    logic [1:0]       ab_prev;
    logic [1:0]       ab_edge;
    logic             any_edge;
    logic [GAP_W-1:0] since_edge;

    qsr_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({b_in, a_in}),
        .q     (ab_sync)
    );

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ab_prev <= '0;
        else        ab_prev <= ab_sync;
    end

    // Find the transitions on each line.
    always_comb begin
        ab_edge  = ab_sync ^ ab_prev;
        any_edge = |ab_edge;
    end

    // Count clocks since the last transition, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_edge <= GAP_MAX;
        else if (any_edge)           since_edge <= '0;
        else if (since_edge != GAP_MAX) since_edge <= since_edge + 1'b1;
    end

    // Flag a transition that comes too soon, or both lines changing at once.
    always_comb begin
        dec_err = (&ab_edge) || (any_edge && (since_edge < min_gap));
    end
endmodule

// File: rtl/qsr_flag_byte.sv
// One status byte of set-dominant latches. Bits outside USED are tied low.
// A set in the same cycle as a clear wins.
module qsr_flag_byte
    import qsr_pkg::*;
#(
    parameter stbyte_t USED = 8'hFF
) (
    input  logic    clk,
    input  logic    rst_n,
    input  stbyte_t set_i,
    input  stbyte_t clr_i,
    output stbyte_t q
);
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (USED[i]) begin : g_latch
            // Latch the event, drop it on clear, set has priority.
            always_ff @(posedge clk) begin
                if (!rst_n)        q[i] <= 1'b0;
                else if (set_i[i]) q[i] <= 1'b1;
                else if (clr_i[i]) q[i] <= 1'b0;
            end
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/qsr_read_port.sv
// One serial read port. It decodes the address against BASE, reports which
// status byte it hits this cycle, and registers the selected byte (or zero
// when no status byte is hit) on each strobe.
module qsr_read_port
    import qsr_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [FLAT_W-1:0]    view,
    output logic [NUM_BYTES-1:0] hit,
    output stbyte_t              data
);
    logic [ADDR_W-1:0] offset;
    stbyte_t           sel_byte;

    // Decode which status byte this strobe addresses.
    always_comb begin
        offset = addr - BASE;
        for (int i = 0; i < NUM_BYTES; i++) begin
            hit[i] = rd_en && (offset == ADDR_W'(i));
        end
    end

    // Select the addressed byte from the view.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (hit[i]) sel_byte = view[i*BYTE_W +: BYTE_W];
        end
    end

    // Register the read result on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     data <= '0;
        else if (rd_en) data <= sel_byte;
    end
endmodule

// File: rtl/quad_status_reg.sv
// Latched status and warning register. Three bytes latch event pulses and
// the quadrature decode error, and clear on status reads from either port.
// Exceptions: the reference-valid bit survives status reads, the two
// capture-valid bits also clear on their data register reads, and the
// probe pin bit is live. Assumes event inputs are synchronous pulses.
module quad_status_reg
    import qsr_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h48,
    parameter int                GAP_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ab_a,
    input  logic              ab_b,
    input  logic [GAP_W-1:0]  min_gap,
    input  logic              ev_ext,
    input  logic [WARN_W-1:0] ev_warn,
    input  logic              ev_tpval,
    input  logic              ev_updval,
    input  logic              ev_rval,
    input  logic              tpi,
    input  logic              rd_probe,
    input  logic              rd_update,
    input  logic              pa_rd,
    input  logic [ADDR_W-1:0] pa_addr,
    output logic [7:0]        pa_data,
    input  logic              pb_rd,
    input  logic [ADDR_W-1:0] pb_addr,
    output logic [7:0]        pb_data,
    output logic              err_o,
    output logic              warn_o
);
    logic                 dec_err;
    logic                 pin_sync;
    logic [NUM_BYTES-1:0] hit_a;
    logic [NUM_BYTES-1:0] hit_b;
    logic [NUM_BYTES-1:0] hit_any;
    stbyte_t              set_v [NUM_BYTES];
    stbyte_t              clr_v [NUM_BYTES];
    stbyte_t              st_v  [NUM_BYTES];
    logic [FLAT_W-1:0]    st_flat;
    logic [FLAT_W-1:0]    view;

    qsr_edge_guard #(.GAP_W(GAP_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_in    (ab_a),
        .b_in    (ab_b),
        .min_gap (min_gap),
        .dec_err (dec_err)
    );

    qsr_sync2 #(.W(1)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tpi),
        .q     (pin_sync)
    );

    // Route event pulses to their bit positions.
    always_comb begin
        set_v[0] = {ev_warn[5:0], ev_ext, dec_err};
        set_v[1] = {ev_warn[9:6], 1'b0, ev_rval, ev_updval, ev_tpval};
        set_v[2] = ev_warn[17:10];
    end

    // Form the per-byte clears from both ports and the data register reads.
    always_comb begin
        hit_any = hit_a | hit_b;
        for (int i = 0; i < NUM_BYTES; i++) begin
            clr_v[i] = hit_any[i] ? ~keep_mask(i) : '0;
        end
        clr_v[1][PVAL_POS] = clr_v[1][PVAL_POS] | rd_probe;
        clr_v[1][UVAL_POS] = clr_v[1][UVAL_POS] | rd_update;
    end

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        qsr_flag_byte #(.USED(used_mask(g))) u_byte (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q     (st_v[g])
        );
        assign st_flat[g*BYTE_W +: BYTE_W] = st_v[g];
    end

    // Build the readable view with the live pin in place.
    always_comb begin
        view = st_flat;
        view[BYTE_W + PIN_POS] = pin_sync;
    end

    qsr_read_port #(.ADDR_W(ADDR_W), .BASE(BASE_ADDR)) u_port_a (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (pa_rd),
        .addr  (pa_addr),
        .view  (view),
        .hit   (hit_a),
        .data  (pa_data)
    );

    qsr_read_port #(.ADDR_W(ADDR_W), .BASE(BASE_ADDR)) u_port_b (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (pb_rd),
        .addr  (pb_addr),
        .view  (view),
        .hit   (hit_b),
        .data  (pb_data)
    );

    // Summarize errors and warnings from the latched bits.
    always_comb begin
        err_o  = 1'b0;
        warn_o = 1'b0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            err_o  = err_o  | (|(st_v[i] & err_mask(i)));
            warn_o = warn_o | (|(st_v[i] & ~err_mask(i)));
        end
    end
endmodule

// File: rtl/qsr_status_chk.sv
// Property checker for quad_status_reg, attached by bind below.
module qsr_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] st_flat,
    input logic [2:0]  hit_any,
    input logic        ev_ext,
    input logic [17:0] ev_warn,
    input logic        ev_tpval,
    input logic        rd_probe,
    input logic        dec_err,
    input logic        err_o
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_flat[1] && !hit_any[0]) |=> st_flat[1]);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_any[2] && (ev_warn[17:10] == 8'h00)) |=> (st_flat[23:16] == 8'h00));

    assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_flat[10] && hit_any[1]) |=> st_flat[10]);

    assert_probe_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_probe && !ev_tpval) |=> !st_flat[8]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ext && hit_any[0]) |=> st_flat[1]);

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(ev_ext || dec_err));

    assert_dec_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |=> st_flat[0]);
endmodule

bind quad_status_reg qsr_status_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_flat  (st_flat),
    .hit_any  (hit_any),
    .ev_ext   (ev_ext),
    .ev_warn  (ev_warn),
    .ev_tpval (ev_tpval),
    .rd_probe (rd_probe),
    .dec_err  (dec_err),
    .err_o    (err_o)
);

// File: tb/sim_quad_status_reg.sv
module sim_quad_status_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ab_a = 1'b0, ab_b = 1'b0;
    logic [7:0]  min_gap = 8'd4;
    logic        ev_ext = 1'b0;
    logic [17:0] ev_warn = '0;
    logic        ev_tpval = 1'b0, ev_updval = 1'b0, ev_rval = 1'b0;
    logic        tpi = 1'b0;
    logic        rd_probe = 1'b0, rd_update = 1'b0;
    logic        pa_rd = 1'b0, pb_rd = 1'b0;
    logic [7:0]  pa_addr = '0, pb_addr = '0;
    logic [7:0]  pa_data, pb_data;
    logic        err_o, warn_o;

    int          n_vec = 0;
    int          n_bad = 0;
    logic        track = 1'b1;
    logic        done  = 1'b0;
    logic [7:0]  exp_st [3];
    logic [1:0]  tpipe = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .ab_a(ab_a), .ab_b(ab_b), .min_gap(min_gap),
        .ev_ext(ev_ext), .ev_warn(ev_warn), .ev_tpval(ev_tpval),
        .ev_updval(ev_updval), .ev_rval(ev_rval), .tpi(tpi),
        .rd_probe(rd_probe), .rd_update(rd_update),
        .pa_rd(pa_rd), .pa_addr(pa_addr), .pa_data(pa_data),
        .pb_rd(pb_rd), .pb_addr(pb_addr), .pb_data(pb_data),
        .err_o(err_o), .warn_o(warn_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    function automatic int idx_of(input logic [7:0] a);
        if (a >= 8'h48 && a <= 8'h4A) return int'(a - 8'h48);
        return 3;
    endfunction

    function automatic logic [7:0] view_of(input int idx);
        logic [7:0] v;
        if (idx > 2) return 8'h00;
        v = exp_st[idx];
        if (idx == 1) v[3] = tpipe[1];
        return v;
    endfunction

    function automatic logic exp_err();
        return exp_st[0][1:0] != 2'b00;
    endfunction

    function automatic logic exp_warn();
        return (|(exp_st[0] & 8'hFC)) | (|exp_st[1]) | (|exp_st[2]);
    endfunction

    // One clock: advance the model, take the edge, compare, clear pulses.
    task automatic step();
        logic [7:0] ea, eb;
        logic [7:0] setv [3];
        logic [7:0] clrv [3];
        logic       da, db;
        int         ia, ib;
        da = pa_rd; db = pb_rd;
        ia = idx_of(pa_addr); ib = idx_of(pb_addr);
        ea = view_of(ia); eb = view_of(ib);
        setv[0] = {ev_warn[5:0], ev_ext, 1'b0};
        setv[1] = {ev_warn[9:6], 1'b0, ev_rval, ev_updval, ev_tpval};
        setv[2] = ev_warn[17:10];
        for (int k = 0; k < 3; k++) begin
            clrv[k] = ((da && ia == k) || (db && ib == k)) ? ((k == 1) ? 8'hFB : 8'hFF) : 8'h00;
        end
        clrv[1] = clrv[1] | {6'b0, rd_update, rd_probe};
        for (int k = 0; k < 3; k++) begin
            exp_st[k] = ((exp_st[k] & ~clrv[k]) | setv[k]) & ((k == 1) ? 8'hF7 : 8'hFF);
        end
        @(posedge clk);
        @(negedge clk);
        tpipe = {tpipe[0], tpi};
        if (track) begin
            if (da) check("R3 port A data", pa_data, ea);
            if (db) check("R4 port B data", pb_data, eb);
            check("R9 err_o", {7'b0, err_o}, {7'b0, exp_err()});
            check("R9 warn_o", {7'b0, warn_o}, {7'b0, exp_warn()});
        end
        ev_ext = 0; ev_warn = '0; ev_tpval = 0; ev_updval = 0; ev_rval = 0;
        rd_probe = 0; rd_update = 0; pa_rd = 0; pb_rd = 0;
    endtask

    task automatic read_a(input logic [7:0] a);
        pa_rd = 1'b1; pa_addr = a;
        step();
    endtask

    // Quadrature case: B moves k clocks after A (k = 0 means together).
    task automatic ab_case(input logic [7:0] gap, input int k, input logic expv, input string tag);
        track = 1'b0;
        min_gap = gap;
        ab_a = ~ab_a;
        if (k == 0) ab_b = ~ab_b;
        else begin
            repeat (k) step();
            ab_b = ~ab_b;
        end
        repeat (8) step();
        read_a(8'h48);
        check(tag, {7'b0, pa_data[0]}, {7'b0, expv});
        repeat (12) step();
        track = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) exp_st[k] = 8'h00;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        check("R12 err_o after reset", {7'b0, err_o}, 8'h00);
        check("R12 warn_o after reset", {7'b0, warn_o}, 8'h00);
        check("R12 pa_data after reset", pa_data, 8'h00);
        check("R12 pb_data after reset", pb_data, 8'h00);

        // R2 latch, then R3 clear on read
        ev_warn[12] = 1'b1; step();
        repeat (3) step();
        read_a(8'h4A); check("R2 latched bit", pa_data, 8'h04);
        read_a(8'h4A); check("R3 cleared after read", pa_data, 8'h00);

        // R1 unmapped addresses return zero and clear nothing
        ev_warn[0] = 1'b1; step();
        read_a(8'h4B); check("R1 addr above", pa_data, 8'h00);
        read_a(8'h47); check("R1 addr below", pa_data, 8'h00);
        read_a(8'h48); check("R1 byte0 intact", pa_data, 8'h04);

        // R3 byte-selective clear
        ev_warn[0] = 1'b1; ev_warn[10] = 1'b1; step();
        read_a(8'h4A); check("R3 byte2 read", pa_data, 8'h01);
        read_a(8'h48); check("R3 byte0 kept", pa_data, 8'h04);

        // R4 either port clears; both ports together
        ev_warn[6] = 1'b1; step();
        pb_rd = 1'b1; pb_addr = 8'h49; step();
        check("R4 port B read", pb_data, 8'h10);
        read_a(8'h49); check("R4 cleared by port B", pa_data, 8'h00);
        ev_warn[11] = 1'b1; step();
        pa_rd = 1'b1; pa_addr = 8'h4A; pb_rd = 1'b1; pb_addr = 8'h4A; step();
        check("R4 dual read A", pa_data, 8'h02);
        check("R4 dual read B", pb_data, 8'h02);
        read_a(8'h4A); check("R4 dual read cleared", pa_data, 8'h00);

        // R6 valid bits cleared by their data register reads
        ev_tpval = 1'b1; ev_updval = 1'b1; step();
        rd_probe = 1'b1; step();
        pb_rd = 1'b1; pb_addr = 8'h49; step();
        check("R6 probe read clears only probe-valid", pb_data, 8'h02);
        ev_tpval = 1'b1; ev_updval = 1'b1; step();
        rd_update = 1'b1; step();
        read_a(8'h49); check("R6 update read clears only update-valid", pa_data, 8'h01);

        // R8 set wins over same-cycle clear
        ev_ext = 1'b1; pa_rd = 1'b1; pa_addr = 8'h48; step();
        check("R8 pre-clear data", pa_data, 8'h00);
        check("R8 err_o set", {7'b0, err_o}, 8'h01);
        read_a(8'h48); check("R8 bit survived", pa_data, 8'h02);

        // R7 live pin, not latched, not a warning
        tpi = 1'b1; repeat (3) step();
        read_a(8'h49); check("R7 pin high", pa_data, 8'h08);
        check("R7 pin not warning", {7'b0, warn_o}, 8'h00);
        read_a(8'h49); check("R7 not cleared", pa_data, 8'h08);
        tpi = 1'b0; repeat (3) step();
        read_a(8'h49); check("R7 pin low", pa_data, 8'h00);

        // R9 summaries
        ev_ext = 1'b1; step();
        check("R9 err from ext", {7'b0, err_o}, 8'h01);
        check("R9 no warn", {7'b0, warn_o}, 8'h00);
        ev_warn[17] = 1'b1; step();
        check("R9 warn from byte2", {7'b0, warn_o}, 8'h01);
        read_a(8'h48); read_a(8'h4A);
        check("R9 err cleared", {7'b0, err_o}, 8'h00);

        // R10 / R11 quadrature decode
        ab_case(8'd4, 10, 1'b0, "R10 wide spacing");
        ab_case(8'd4, 2,  1'b1, "R10 close spacing");
        ab_case(8'd4, 4,  1'b1, "R10 spacing equal to gap");
        ab_case(8'd4, 5,  1'b0, "R10 spacing gap plus one");
        ab_case(8'd0, 1,  1'b0, "R10 check disabled");
        ab_case(8'd0, 0,  1'b1, "R11 simultaneous change");

        // R5 reference-valid survives status reads
        ev_rval = 1'b1; step();
        read_a(8'h49); check("R5 first read", pa_data, 8'h04);
        read_a(8'h49); check("R5 second read", pa_data, 8'h04);
        check("R5 still warning", {7'b0, warn_o}, 8'h01);

        // Random phase against the model
        for (int n = 0; n < 3000; n++) begin
            ev_warn   = 18'($urandom & $urandom & $urandom & $urandom & $urandom);
            ev_ext    = ($urandom % 16) == 0;
            ev_tpval  = ($urandom % 8) == 0;
            ev_updval = ($urandom % 8) == 0;
            ev_rval   = ($urandom % 64) == 0;
            rd_probe  = ($urandom % 8) == 0;
            rd_update = ($urandom % 8) == 0;
            pa_rd     = ($urandom % 2) == 0;
            pa_addr   = 8'h47 + 8'($urandom % 5);
            pb_rd     = ($urandom % 3) == 0;
            pb_addr   = 8'h47 + 8'($urandom % 5);
            if (($urandom % 8) == 0) tpi = ~tpi;
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule